// File: doc/BRIEF.md
# Funnel Shifter with Fill Operand

This block shifts a base word of width W left or right by a variable amount. The bit positions the shift vacates are not loaded with zeros or copies of the sign. They are loaded from a second operand, the fill word, whose width H is set independently of W. A left shift pulls bits in from the most significant end of the fill word. A right shift pulls bits in from the least significant end. The result is always W bits wide, whatever the value of H.

The shift itself is combinational. The result and an out-of-range flag are captured in one output register stage that has a synchronous active-high reset. An amount greater than H has no meaningful result. For such an amount the block raises the flag and outputs all zeros, so the output is still deterministic. The amount port is wide enough to hold any value up to max(W, H), so values above H can be presented and are detected.

Top module: `funnel_shift_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_o` and `range_err_o` are both cleared to zero after that edge, whatever the data inputs are.
- R2: With `amt_i` equal to 0, in either direction, `res_o` equals `base_i` and `range_err_o` is low.
- R3: With `dir_i` = 0 (left) and 0 < `amt_i` ≤ H, `res_o` is the upper W bits of the (W+H)-bit word {`base_i`, `fill_i`} shifted left by `amt_i`. Bit 0 of the result therefore takes `fill_i[H-1]` when the amount is 1.
- R4: With `dir_i` = 1 (right) and 0 < `amt_i` ≤ H, `res_o` is the lower W bits of {`fill_i`, `base_i`} shifted right by `amt_i`. Bit W-1 of the result therefore takes `fill_i[0]` when the amount is 1.
- R5: When `amt_i` > H, `range_err_o` is 1 and `res_o` is all zeros in both directions. When `amt_i` ≤ H, `range_err_o` is 0.
- R6: An amount exactly equal to H is in range. The whole fill word enters the result, and `range_err_o` stays low.
- R7: Each result and flag appears at the first rising clock edge after the inputs are applied. Before that edge, the outputs keep their previous values.
- R8: With W = H = 4, a base of 0xF and a fill of 0xC, an amount of 3 gives 0xE to the left and 0x9 to the right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | W | Word to be shifted |
| fill_i | input | H | Word that supplies the vacated positions |
| amt_i | input | AW = clog2(max(W,H)+1) | Shift amount |
| dir_i | input | 1 | Direction: 0 = left, 1 = right |
| res_o | output | W | Registered shift result |
| range_err_o | output | 1 | Registered flag: amount exceeded H |

## Verification
Both `res_o` and `range_err_o` are due exactly one rising edge after the inputs that produce them. The bench changes inputs on falling edges and compares on the following falling edge. That compare point sits after the single register on the path and before the next input change. One check changes the inputs and samples just before the next rising edge, to confirm the outputs still hold the previous result. The bench then sweeps every base, fill, amount and direction on a 6-bit-base, 3-bit-fill instance. It also sweeps a square 4-by-4 instance that covers the worked 0xF/0xC values. Expected values are built from integer multiply, divide and mask arithmetic.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    typedef enum logic {
        SHIFT_LEFT  = 1'b0,
        SHIFT_RIGHT = 1'b1
    } shift_dir_e;

    function automatic int unsigned larger_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // bits needed to hold every amount from 0 up to max(w, h)
    function automatic int unsigned amt_bits(input int unsigned w, input int unsigned h);
        return $clog2(larger_of(w, h) + 1);
    endfunction

endpackage

// File: rtl/fsh_bound_chk.sv
module fsh_bound_chk #(
    parameter int H  = 5,
    parameter int AW = 4
) (
    input  logic [AW-1:0] amt_i,
    output logic          over_o
);
    localparam logic [AW-1:0] H_LIMIT = AW'(H);

    always_comb begin
        over_o = (amt_i > H_LIMIT);
    end
endmodule

// File: rtl/fsh_core.sv
module fsh_core
    import fsh_pkg::*;
#(
    parameter int W  = 8,
    parameter int H  = 5,
    parameter int AW = 4
) (
    input  logic [W-1:0]  base_i,
    input  logic [H-1:0]  fill_i,
    input  logic [AW-1:0] amt_i,
    input  shift_dir_e    dir_i,
    output logic [W-1:0]  res_o
);
    localparam int CW = W + H;
    localparam logic [AW-1:0] H_AMT = AW'(H);

    logic [CW-1:0] left_cat;
    logic [CW-1:0] right_cat;
    logic [AW-1:0] left_drop;
    logic [W-1:0]  left_res;
    logic [W-1:0]  right_res;

    always_comb begin
        left_cat  = {base_i, fill_i};
        right_cat = {fill_i, base_i};
        // the top W bits of (cat << amt) equal the W bits at offset H-amt
        left_drop = H_AMT - amt_i;
        left_res  = W'(left_cat >> left_drop);
        right_res = W'(right_cat >> amt_i);
        res_o     = (dir_i == SHIFT_LEFT) ? left_res : right_res;
    end

    // R2: a zero amount must return the base word in both directions
    always_comb begin
        if (amt_i == '0) begin
            p_zero_pass_r2: assert (res_o == base_i);
        end
    end
endmodule

// File: rtl/fsh_out_reg.sv
module fsh_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] res_d,
    input  logic         err_d,
    output logic [W-1:0] res_q,
    output logic         err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            err_q <= 1'b0;
        end else begin
            res_q <= res_d;
            err_q <= err_d;
        end
    end
endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit
    import fsh_pkg::*;
#(
    parameter int W  = 8,
    parameter int H  = 5,
    parameter int AW = fsh_pkg::amt_bits(W, H)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  base_i,
    input  logic [H-1:0]  fill_i,
    input  logic [AW-1:0] amt_i,
    input  logic          dir_i,
    output logic [W-1:0]  res_o,
    output logic          range_err_o
);
    localparam logic [AW-1:0] H_AMT = AW'(H);

    shift_dir_e   dir_sel;
    logic [W-1:0] core_res;
    logic [W-1:0] masked_res;
    logic         over;

    assign dir_sel = shift_dir_e'(dir_i);

    fsh_core #(.W(W), .H(H), .AW(AW)) u_core (
        .base_i (base_i),
        .fill_i (fill_i),
        .amt_i  (amt_i),
        .dir_i  (dir_sel),
        .res_o  (core_res)
    );

    fsh_bound_chk #(.H(H), .AW(AW)) u_bound (
        .amt_i  (amt_i),
        .over_o (over)
    );

    // undefined amounts give a deterministic all-zero word
    always_comb begin
        masked_res = over ? '0 : core_res;
    end

    fsh_out_reg #(.W(W)) u_oreg (
        .clk   (clk),
        .rst   (rst),
        .res_d (masked_res),
        .err_d (over),
        .res_q (res_o),
        .err_q (range_err_o)
    );

    p_err_zero_r5: assert property (@(posedge clk) disable iff (rst)
        range_err_o |-> (res_o == '0));

    p_err_flag_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (range_err_o == ($past(amt_i) > H_AMT)));

    p_zero_amt_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(amt_i) == '0)) |-> (res_o == $past(base_i)));

    p_left_lsb_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(dir_i) && ($past(amt_i) == AW'(1)))
            |-> (res_o[0] == $past(fill_i[H-1])));

    p_right_msb_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dir_i) && ($past(amt_i) == AW'(1)))
            |-> (res_o[W-1] == $past(fill_i[0])));

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (res_o == '0 && !range_err_o));
endmodule

// File: tb/funnel_shift_unit_tb.sv
`timescale 1ns/100ps
module funnel_shift_unit_tb;
    localparam int W1 = 6;
    localparam int H1 = 3;
    localparam int A1 = 3;
    localparam int W2 = 4;
    localparam int H2 = 4;
    localparam int A2 = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W1-1:0] b1;
    logic [H1-1:0] f1;
    logic [A1-1:0] a1;
    logic          d1;
    logic [W1-1:0] r1;
    logic          e1;

    logic [W2-1:0] b2;
    logic [H2-1:0] f2;
    logic [A2-1:0] a2;
    logic          d2;
    logic [W2-1:0] r2;
    logic          e2;

    funnel_shift_unit #(.W(W1), .H(H1)) u_dut (
        .clk(clk), .rst(rst), .base_i(b1), .fill_i(f1), .amt_i(a1), .dir_i(d1),
        .res_o(r1), .range_err_o(e1));

    funnel_shift_unit #(.W(W2), .H(H2)) u_dut_sq (
        .clk(clk), .rst(rst), .base_i(b2), .fill_i(f2), .amt_i(a2), .dir_i(d2),
        .res_o(r2), .range_err_o(e2));

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    function automatic longint unsigned model(input int w, input int h,
            input longint unsigned b, input longint unsigned f, input int a,
            input bit d, output bit err);
        longint unsigned mask;
        mask = (64'd1 << w) - 1;
        if (a > h) begin
            err = 1'b1;
            return 0;
        end
        err = 1'b0;
        if (!d)
            return ((((b * (64'd1 << h)) + f) * (64'd1 << a)) / (64'd1 << h)) & mask;
        return (((f * (64'd1 << w)) + b) / (64'd1 << a)) & mask;
    endfunction

    task automatic check(input string req, input longint unsigned got_r,
            input longint unsigned exp_r, input bit got_e, input bit exp_e);
        n_chk++;
        if (got_r !== exp_r || got_e !== exp_e) begin
            n_fail++;
            $display("FAIL %s: res=%0h err=%0b expected res=%0h err=%0b",
                     req, got_r, got_e, exp_r, exp_e);
        end
    endtask

    function automatic string tag_for(input int a, input int h, input bit d);
        if (a > h)  return "R5";
        if (a == 0) return "R2";
        if (a == h) return "R6";
        return d ? "R4" : "R3";
    endfunction

    initial begin
        bit e;
        longint unsigned x;
        b1 = '1; f1 = '1; a1 = 3'd1; d1 = 1'b0;
        b2 = '1; f2 = '1; a2 = 3'd1; d2 = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", r1, 0, e1, 1'b0);
        check("R1", r2, 0, e2, 1'b0);
        rst = 1'b0;

        // R8: the worked 4-bit values
        b2 = 4'hF; f2 = 4'hC; a2 = 3'd3; d2 = 1'b0;
        @(negedge clk);
        check("R8", r2, 64'hE, e2, 1'b0);
        d2 = 1'b1;
        // R7: before the next rising edge the old result is still held
        #1;
        check("R7", r2, 64'hE, e2, 1'b0);
        @(negedge clk);
        check("R8", r2, 64'h9, e2, 1'b0);

        // exhaustive sweep of the 6-bit base / 3-bit fill instance
        for (int d = 0; d < 2; d++)
            for (int a = 0; a < (1 << A1); a++)
                for (int f = 0; f < (1 << H1); f++)
                    for (int b = 0; b < (1 << W1); b++) begin
                        b1 = W1'(b); f1 = H1'(f); a1 = A1'(a); d1 = d[0];
                        @(negedge clk);
                        x = model(W1, H1, b, f, a, d[0], e);
                        check(tag_for(a, H1, d[0]), r1, x, e1, e);
                    end

        // exhaustive sweep of the square 4-bit instance
        for (int d = 0; d < 2; d++)
            for (int a = 0; a < (1 << A2); a++)
                for (int f = 0; f < (1 << H2); f++)
                    for (int b = 0; b < (1 << W2); b++) begin
                        b2 = W2'(b); f2 = H2'(f); a2 = A2'(a); d2 = d[0];
                        @(negedge clk);
                        x = model(W2, H2, b, f, a, d[0], e);
                        check(tag_for(a, H2, d[0]), r2, x, e2, e);
                    end

        // R1 again: reset in mid-operation clears both outputs
        b1 = '1; f1 = '1; a1 = 3'd2; d1 = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R1", r1, 0, e1, 1'b0);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule